// File: doc/BRIEF.md
# Eight-Bit Function-Coded Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit for an 8-bit datapath. It takes two operands, `b_i` and `c_i`, and a 3-bit function code. It returns one result byte and three condition flags: carry, sign and zero. All candidate results are computed in parallel. One shared ripple-carry adder covers addition and increment. A per-bit logic slice covers AND, OR, XOR, complement and a circular left rotate.

A 3-to-8 decoder turns the function code into one-hot enables. Only the enabled candidate reaches the internal result lines. A separate result-enable input decides whether that value is driven out or whether the output stays at all zeros, so several units can share one wired-OR data bus. The flags always describe the selected operation, whatever the state of the result enable. The flags are meant to be captured by a condition register outside the block. The operand registers and the control sequencer are also outside.

Top module: `alu8_core`

## Requirements
- R1: Function code 000 gives (b_i + c_i) modulo 256 on the result, and carry_o is the carry out of bit 7 of that sum.
- R2: Function code 001 gives (b_i + 1) modulo 256, and carry_o is 1 exactly when b_i is 8'hFF; c_i has no effect.
- R3: Function codes 010, 011 and 100 give the bitwise AND, OR and XOR of b_i and c_i, in that order.
- R4: Function code 101 gives the bitwise complement of b_i, and c_i has no effect on the result.
- R5: Function code 110 rotates b_i left by one place: result bit 0 takes b_i bit 7, and result bit k (k from 1 to 7) takes b_i bit k-1.
- R6: Function code 111 selects no unit, so the result is 8'h00 for any operands.
- R7: carry_o is 0 for function codes 010 through 111.
- R8: zero_o is 1 exactly when all eight bits of the selected result are 0.
- R9: sign_o equals bit 7 of the selected result.
- R10: When res_en_i is 0, res_o is 8'h00 for every function code and operand. carry_o, sign_o and zero_o still describe the selected result, as if res_en_i were 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| b_i | input | 8 | First operand; the only source for increment, complement and rotate |
| c_i | input | 8 | Second operand |
| func_i | input | 3 | Function code (000 add, 001 inc, 010 and, 011 or, 100 xor, 101 not, 110 rotate-left, 111 none) |
| res_en_i | input | 1 | 1 drives the selected result on res_o; 0 forces res_o to zero |
| res_o | output | 8 | Result byte |
| carry_o | output | 1 | Carry out of the adder for add and increment, otherwise 0 |
| sign_o | output | 1 | Bit 7 of the selected result |
| zero_o | output | 1 | Selected result is all zeros |

## Verification
The block has no registers, so every output is due in the same cycle its inputs change. It only has to settle through the decoder and at most eight adder carry stages. The bench changes the operands, function code and enable just after a rising edge and records the expected result byte and flags. The monitor compares those values at the next falling edge, half a period later, so the result is due in that same cycle and no edge race affects the check. The stimulus includes carry out of bit 7, increment of 8'hFF, rotate of a set top bit, zero results from each unit, and operations with the result enable low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned FUNC_W = 3;
  localparam int unsigned NUM_FN = 1 << FUNC_W;

  typedef enum logic [FUNC_W-1:0] {
    FN_ADD = 3'd0,
    FN_INC = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_XOR = 3'd4,
    FN_NOT = 3'd5,
    FN_SHL = 3'd6,
    FN_NOP = 3'd7
  } fn_e;
endpackage

// File: rtl/alu8_ripple_add.sv
module alu8_ripple_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] cy;

  assign cy[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic hs;
    assign hs       = a_i[i] ^ b_i[i];
    assign sum_o[i] = hs ^ cy[i];
    assign cy[i+1]  = (a_i[i] & b_i[i]) | (cy[i] & hs);
  end

  assign cout_o = cy[W];
endmodule

// File: rtl/alu8_logic_slice.sv
module alu8_logic_slice #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o,
  output logic [W-1:0] not_o,
  output logic [W-1:0] rol_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_o[i] = b_i[i] & c_i[i];
    assign or_o[i]  = b_i[i] | c_i[i];
    assign xor_o[i] = b_i[i] ^ c_i[i];
    assign not_o[i] = ~b_i[i];
    // circular: bit 0 takes the top bit
    if (i == 0) begin : g_wrap
      assign rol_o[i] = b_i[W-1];
    end else begin : g_move
      assign rol_o[i] = b_i[i-1];
    end
  end
endmodule

// File: rtl/alu8_fn_decode.sv
module alu8_fn_decode
  import alu8_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output logic [NUM_FN-1:0] sel_o
);
  for (genvar i = 0; i < NUM_FN; i++) begin : g_dec
    assign sel_o[i] = (func_i == FUNC_W'(i));
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]      b_i,
  input  logic [W-1:0]      c_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic              res_en_i,
  output logic [W-1:0]      res_o,
  output logic              carry_o,
  output logic              sign_o,
  output logic              zero_o
);
  logic [NUM_FN-1:0] sel_oh;
  logic [W-1:0]      add_rhs;
  logic [W-1:0]      add_sum;
  logic              add_cout;
  logic [W-1:0]      and_v, or_v, xor_v, not_v, rol_v;
  logic [W-1:0]      cand [NUM_FN];
  logic [W-1:0]      sel_res;

  alu8_fn_decode u_dec (
    .func_i (func_i),
    .sel_o  (sel_oh)
  );

  // one adder shared by add and increment
  assign add_rhs = sel_oh[FN_INC] ? W'(1) : c_i;

  alu8_ripple_add #(.W(W)) u_add (
    .a_i    (b_i),
    .b_i    (add_rhs),
    .cin_i  (1'b0),
    .sum_o  (add_sum),
    .cout_o (add_cout)
  );

  alu8_logic_slice #(.W(W)) u_log (
    .b_i   (b_i),
    .c_i   (c_i),
    .and_o (and_v),
    .or_o  (or_v),
    .xor_o (xor_v),
    .not_o (not_v),
    .rol_o (rol_v)
  );

  assign cand[FN_ADD] = add_sum;
  assign cand[FN_INC] = add_sum;
  assign cand[FN_AND] = and_v;
  assign cand[FN_OR]  = or_v;
  assign cand[FN_XOR] = xor_v;
  assign cand[FN_NOT] = not_v;
  assign cand[FN_SHL] = rol_v;
  assign cand[FN_NOP] = '0;

  // wired-OR of gated candidates, one enable live at a time
  always_comb begin
    sel_res = '0;
    for (int i = 0; i < NUM_FN; i++) begin
      sel_res = sel_res | (cand[i] & {W{sel_oh[i]}});
    end
  end

  assign carry_o = add_cout & (sel_oh[FN_ADD] | sel_oh[FN_INC]);
  assign sign_o  = sel_res[W-1];
  assign zero_o  = ~|sel_res;
  assign res_o   = res_en_i ? sel_res : '0;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic [W-1:0]      b_i,
  input logic [W-1:0]      c_i,
  input logic [FUNC_W-1:0] func_i,
  input logic              res_en_i,
  input logic [W-1:0]      res_o,
  input logic              carry_o,
  input logic              sign_o,
  input logic              zero_o
);
  logic [W:0] wide_sum;
  logic [W:0] wide_inc;

  assign wide_sum = {1'b0, b_i} + {1'b0, c_i};
  assign wide_inc = {1'b0, b_i} + (W+1)'(1);

  always_comb begin
    if (res_en_i && func_i == FN_ADD)
      p_add_r1: assert ({carry_o, res_o} == wide_sum) else $error("r1 add");
    if (res_en_i && func_i == FN_INC)
      p_inc_r2: assert ({carry_o, res_o} == wide_inc) else $error("r2 inc");
    if (res_en_i && func_i == FN_XOR)
      p_xor_r3: assert ((res_o ^ b_i) == c_i) else $error("r3 xor");
    if (res_en_i && func_i == FN_NOT)
      p_not_r4: assert ((res_o ^ b_i) == '1) else $error("r4 not");
    if (res_en_i && func_i == FN_SHL)
      p_rol_r5: assert ((res_o[0] == b_i[W-1]) && (res_o[W-1:1] == b_i[W-2:0]))
        else $error("r5 rotate");
    if (func_i == FN_NOP)
      p_nop_r6: assert ((res_o == '0) && zero_o && !sign_o) else $error("r6 nop");
    if (func_i != FN_ADD && func_i != FN_INC)
      p_carry_r7: assert (!carry_o) else $error("r7 carry");
    if (res_en_i)
      p_zero_r8: assert (zero_o == (res_o == '0)) else $error("r8 zero");
    if (res_en_i)
      p_sign_r9: assert (sign_o == res_o[W-1]) else $error("r9 sign");
    if (!res_en_i)
      p_gate_r10: assert (res_o == '0) else $error("r10 gate");
  end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
  .b_i      (b_i),
  .c_i      (c_i),
  .func_i   (func_i),
  .res_en_i (res_en_i),
  .res_o    (res_o),
  .carry_o  (carry_o),
  .sign_o   (sign_o),
  .zero_o   (zero_o)
);

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
  logic       clk;
  logic       rst_ni;
  logic [7:0] b_i, c_i;
  logic [2:0] func_i;
  logic       res_en_i;
  logic [7:0] res_o;
  logic       carry_o, sign_o, zero_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit driver_done = 0;

  typedef struct {
    logic [7:0] res;
    logic       cy;
    logic       sg;
    logic       zr;
    string      tag;
  } exp_t;

  exp_t sb[$];

  alu8_core u_alu8_core (
    .b_i      (b_i),
    .c_i      (c_i),
    .func_i   (func_i),
    .res_en_i (res_en_i),
    .res_o    (res_o),
    .carry_o  (carry_o),
    .sign_o   (sign_o),
    .zero_o   (zero_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic exp_t model(logic [7:0] b, logic [7:0] c, logic [2:0] f,
                                 logic en, string tag);
    exp_t e;
    logic [8:0] w;
    logic [7:0] r;
    w = 9'd0;
    case (f)
      3'd0: w = {1'b0, b} + {1'b0, c};
      3'd1: w = {1'b0, b} + 9'd1;
      3'd2: w = {1'b0, b & c};
      3'd3: w = {1'b0, b | c};
      3'd4: w = {1'b0, b ^ c};
      3'd5: w = {1'b0, ~b};
      3'd6: w = {1'b0, b[6:0], b[7]};
      default: w = 9'd0;
    endcase
    r     = w[7:0];
    e.res = en ? r : 8'h00;
    e.cy  = w[8];
    e.sg  = r[7];
    e.zr  = (r == 8'h00);
    e.tag = tag;
    return e;
  endfunction

  task automatic apply(logic [7:0] b, logic [7:0] c, logic [2:0] f, logic en,
                       string tag);
    @(posedge clk);
    #1;
    b_i = b; c_i = c; func_i = f; res_en_i = en;
    sb.push_back(model(b, c, f, en, tag));
  endtask

  // monitor: results are due in the same cycle, sampled at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_vec++;
        if ({res_o, carry_o, sign_o, zero_o} !== {e.res, e.cy, e.sg, e.zr}) begin
          n_fail++;
          $display("FAIL %s: got res=%h c=%b s=%b z=%b, want res=%h c=%b s=%b z=%b",
                   e.tag, res_o, carry_o, sign_o, zero_o, e.res, e.cy, e.sg, e.zr);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!driver_done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [6];
    b_i = 0; c_i = 0; func_i = 0; res_en_i = 1; rst_ni = 0;
    // reset state: zero operands under add give a zero result, R8
    apply(8'h00, 8'h00, 3'd0, 1'b1, "R8 reset");
    repeat (2) @(posedge clk);
    rst_ni = 1;

    apply(8'h12, 8'h34, 3'd0, 1'b1, "R1 add");
    apply(8'hFF, 8'h01, 3'd0, 1'b1, "R1 add carry zero");
    apply(8'h80, 8'h80, 3'd0, 1'b1, "R1 add top carry");
    apply(8'h7F, 8'h01, 3'd0, 1'b1, "R9 add sign");
    apply(8'hFF, 8'h55, 3'd1, 1'b1, "R2 inc wrap");
    apply(8'h7F, 8'hAA, 3'd1, 1'b1, "R2 inc sign");
    apply(8'h00, 8'hFF, 3'd1, 1'b1, "R2 inc zero");
    apply(8'hF0, 8'h3C, 3'd2, 1'b1, "R3 and");
    apply(8'h0F, 8'hF0, 3'd2, 1'b1, "R3 and zero");
    apply(8'hF0, 8'h3C, 3'd3, 1'b1, "R3 or");
    apply(8'hF0, 8'h3C, 3'd4, 1'b1, "R3 xor");
    apply(8'hA5, 8'hA5, 3'd4, 1'b1, "R3 xor zero");
    apply(8'hFF, 8'h00, 3'd5, 1'b1, "R4 not zero");
    apply(8'h00, 8'hAA, 3'd5, 1'b1, "R4 not ignores c");
    apply(8'h81, 8'h00, 3'd6, 1'b1, "R5 rotate wrap");
    apply(8'h80, 8'hFF, 3'd6, 1'b1, "R5 rotate top only");
    apply(8'h40, 8'h00, 3'd6, 1'b1, "R5 rotate into sign");
    apply(8'hFF, 8'hFF, 3'd7, 1'b1, "R6 nop");
    apply(8'hFF, 8'hFF, 3'd3, 1'b1, "R7 or no carry");
    apply(8'hFF, 8'h01, 3'd0, 1'b0, "R10 disabled add flags");
    apply(8'h80, 8'h00, 3'd3, 1'b0, "R10 disabled or sign");

    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h80;
    pats[3] = 8'h01; pats[4] = 8'h5A; pats[5] = 8'hC3;
    for (int f = 0; f < 8; f++) begin
      for (int p = 0; p < 6; p++) begin
        for (int en = 0; en < 2; en++) begin
          apply(pats[p], pats[(p + 3) % 6], 3'(f), 1'(en),
                en == 0 ? "R10 sweep" : "R9 sweep");
        end
      end
    end

    @(posedge clk);
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    driver_done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule